// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block counts hardware events for performance analysis. It holds four physical counters of 32 bits. Software can run each one as a single 32-bit counter or cut it into two separate 16-bit counters, so up to eight logical counters exist at once. Every logical counter has its own event input and its own control register, whose bit 0 allows it to count. A global control register holds the run bit and one width bit per physical counter.

Software never writes a live counter directly. A write to a counter address fills a holding latch. The latched values of all four counters move into the live counters when the global control register is written with its run bit at 1. This happens even if the bank is already running, so rewriting the control word reloads the counters.

When a counter rolls over, it raises a sticky status bit for its logical counter. A read of the status register returns the pending bits and clears them. A write to the same address loads a mask, and the interrupt output is raised while any pending bit is also set in that mask. All registers are 32 bits wide and use the upper half of a 64-bit bus word.

Top module: `splitCtrBank`

## Requirements
- R1: After reset, every live counter, every latch, all control registers, the status bits and the interrupt mask are zero, the bank is stopped, `irqOut` is low and `rdData` is zero.
- R2: A write to address 0–3 changes only the latch of physical counter 0–3, and a read of that address still returns the old live value. A write to address 16 with bit 31 of the register value set copies all four latches into the live counters at that clock edge.
- R3: A write to address 16 with bit 31 set reloads the counters from the latches even when the bank is already running. In that cycle the reload replaces any increment.
- R4: With bit n (n = 0..3) of the global register clear, physical counter n is one 32-bit counter. It adds 1 on each clock edge at which the bank runs, `events[n]` is high and bit 0 of logical control register n is set. `events[n+4]` has no effect on it.
- R5: With bit n of the global register set, bits 31:16 of physical counter n form logical counter n and bits 15:0 form logical counter n+4. Each half counts its own event input, gated by its own control register, and no carry passes between the halves.
- R6: While bit 31 of the global register is clear, no live counter changes unless a reload takes place.
- R7: A roll-over from all ones to zero sets a status bit. A 32-bit counter n sets bit n. In 16-bit mode the upper half sets bit n and the lower half sets bit n+4. A status bit stays set until the status register is read.
- R8: A read of address 17 returns the status bits in register bits 7:0 and clears them at the same edge. A roll-over at that same edge leaves its bit set for the next read.
- R9: A write to address 17 loads register bits 7:0 into the interrupt mask. `irqOut` is high exactly when some status bit is also set in the mask, so a mask of zero holds it low.
- R10: Register values travel on bus bits 63:32. Bits 31:0 read back as zero and are ignored on writes. Read data appears on `rdData` one clock after the edge at which `regRd` is sampled high, and unmapped addresses read as zero.
- R11: Addresses 8–15 hold the 32-bit control registers of logical counters 0–7, and address 16 holds the global register. Each reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 5 | Register address |
| wrData | input | 64 | Write data, register value on bits 63:32 |
| events | input | 8 | Event input per logical counter |
| rdData | output | 64 | Registered read data, register value on bits 63:32 |
| irqOut | output | 1 | Interrupt: pending status bits masked by the enable mask |

## Verification
The bench forces two same-cycle collisions on purpose.

The first is a status read that lands on the exact edge where a counter loaded with all ones rolls over. The read must return the older value, and the new bit must survive to the next read.

The second is a reload of the control word while a counting event is asserted. The counter must then hold the latched value with no increment added.

A behavioural model judges both collisions, and so do literal expected values and bound properties on the status and reload paths.

// File: rtl/split_ctr_pkg.sv
package split_ctr_pkg;
  localparam int PHYS_N    = 4;
  localparam int LOG_N     = 2 * PHYS_N;
  localparam int REG_W     = 32;
  localparam int HALF_W    = REG_W / 2;
  localparam int BUS_W     = 64;
  localparam int ADDR_W    = 5;
  localparam int EN_BIT    = 31;
  localparam int PIDX_W    = $clog2(PHYS_N);
  localparam int LIDX_W    = $clog2(LOG_N);
  localparam int LCTL_BASE = 8;
  localparam int GLOB_ADDR = 16;
  localparam int STAT_ADDR = 17;

  typedef struct packed {
    logic              commit;
    logic [PHYS_N-1:0] latchWr;
    logic [REG_W-1:0]  wrVal;
    logic [PHYS_N-1:0] halfMode;
    logic [LOG_N-1:0]  incStrobe;
  } ctrStrobes_t;
endpackage

// File: rtl/splitCtrPath.sv
module splitCtrPath
  import split_ctr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrStrobes_t             stb,
  output logic [PHYS_N*REG_W-1:0] liveFlat,
  output logic [PHYS_N*REG_W-1:0] latchFlat,
  output logic [LOG_N-1:0]        wrapHit
);
  for (genvar n = 0; n < PHYS_N; n++) begin : gCtr
    logic [REG_W-1:0]  liveQ;
    logic [REG_W-1:0]  latchQ;
    logic [REG_W-1:0]  liveNext;
    logic [HALF_W-1:0] hiQ;
    logic [HALF_W-1:0] loQ;
    logic              hiInc;
    logic              loInc;

    assign hiQ   = liveQ[REG_W-1:HALF_W];
    assign loQ   = liveQ[HALF_W-1:0];
    assign hiInc = stb.incStrobe[n];
    assign loInc = stb.incStrobe[n+PHYS_N];

    always_comb begin
      if (stb.halfMode[n])
        liveNext = {hiQ + HALF_W'(hiInc), loQ + HALF_W'(loInc)};
      else
        liveNext = liveQ + REG_W'(hiInc);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ  <= '0;
        latchQ <= '0;
      end else begin
        if (stb.latchWr[n]) latchQ <= stb.wrVal;
        if (stb.commit) liveQ <= latchQ;
        else            liveQ <= liveNext;
      end
    end

    // A reload hides any roll-over in the same cycle.
    assign wrapHit[n] = !stb.commit && hiInc &&
                        (stb.halfMode[n] ? (&hiQ) : (&liveQ));
    assign wrapHit[n+PHYS_N] = !stb.commit && stb.halfMode[n] && loInc && (&loQ);

    assign liveFlat[n*REG_W +: REG_W]  = liveQ;
    assign latchFlat[n*REG_W +: REG_W] = latchQ;
  end
endmodule

// File: rtl/splitCtrCtrl.sv
module splitCtrCtrl
  import split_ctr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic                    regRd,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [BUS_W-1:0]        wrData,
  input  logic [LOG_N-1:0]        events,
  input  logic [LOG_N-1:0]        wrapHit,
  input  logic [PHYS_N*REG_W-1:0] liveFlat,
  output ctrStrobes_t             stb,
  output logic [BUS_W-1:0]        rdData,
  output logic                    irqOut,
  output logic                    enableQ,
  output logic [LOG_N-1:0]        statusQ,
  output logic [LOG_N-1:0]        maskQ
);
  logic [REG_W-1:0] lctlQ [LOG_N];
  logic [REG_W-1:0] globQ;
  logic [REG_W-1:0] liveArr [PHYS_N];
  logic [REG_W-1:0] wrWord;
  logic [REG_W-1:0] rdWord;
  logic             selCtr, selLctl, selGlob, selStat;
  logic [PIDX_W-1:0] ctrIdx;
  logic [LIDX_W-1:0] lctlIdx;
  logic             unusedLowBits;

  assign wrWord        = wrData[BUS_W-1 -: REG_W];
  assign unusedLowBits = ^wrData[BUS_W-REG_W-1:0];
  assign ctrIdx        = regAddr[PIDX_W-1:0];
  assign lctlIdx       = regAddr[LIDX_W-1:0];

  assign selCtr  = regAddr < ADDR_W'(PHYS_N);
  assign selLctl = (regAddr >= ADDR_W'(LCTL_BASE)) && (regAddr < ADDR_W'(LCTL_BASE + LOG_N));
  assign selGlob = regAddr == ADDR_W'(GLOB_ADDR);
  assign selStat = regAddr == ADDR_W'(STAT_ADDR);

  for (genvar n = 0; n < PHYS_N; n++) begin : gUnpack
    assign liveArr[n]      = liveFlat[n*REG_W +: REG_W];
    assign stb.latchWr[n]  = regWr && selCtr && (ctrIdx == PIDX_W'(n));
  end

  for (genvar k = 0; k < LOG_N; k++) begin : gLctl
    always_ff @(posedge clk) begin
      if (!rstN)
        lctlQ[k] <= '0;
      else if (regWr && selLctl && (lctlIdx == LIDX_W'(k)))
        lctlQ[k] <= wrWord;
    end
    assign stb.incStrobe[k] = enableQ && lctlQ[k][0] && events[k];
  end

  assign enableQ      = globQ[EN_BIT];
  assign stb.commit   = regWr && selGlob && wrWord[EN_BIT];
  assign stb.wrVal    = wrWord;
  assign stb.halfMode = globQ[PHYS_N-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globQ   <= '0;
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (regWr && selGlob) globQ <= wrWord;
      if (regWr && selStat) maskQ <= wrWord[LOG_N-1:0];
      // Clear on read, but a roll-over at the same edge stays pending.
      statusQ <= ((regRd && selStat) ? '0 : statusQ) | wrapHit;
    end
  end

  always_comb begin
    rdWord = '0;
    if (selCtr)       rdWord = liveArr[ctrIdx];
    else if (selLctl) rdWord = lctlQ[lctlIdx];
    else if (selGlob) rdWord = globQ;
    else if (selStat) rdWord = REG_W'(statusQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (regRd)
      rdData <= {rdWord, {(BUS_W-REG_W){1'b0}}};
  end

  assign irqOut = |(statusQ & maskQ);
endmodule

// File: rtl/splitCtrBank.sv
module splitCtrBank
  import split_ctr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [LOG_N-1:0]  events,
  output logic [BUS_W-1:0]  rdData,
  output logic              irqOut
);
  ctrStrobes_t             stb;
  logic [PHYS_N*REG_W-1:0] liveFlat;
  logic [PHYS_N*REG_W-1:0] latchFlat;
  logic [LOG_N-1:0]        wrapHit;
  logic                    enableQ;
  logic [LOG_N-1:0]        statusQ;
  logic [LOG_N-1:0]        maskQ;

  splitCtrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .events(events), .wrapHit(wrapHit), .liveFlat(liveFlat),
    .stb(stb), .rdData(rdData), .irqOut(irqOut), .enableQ(enableQ),
    .statusQ(statusQ), .maskQ(maskQ)
  );

  splitCtrPath uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .liveFlat(liveFlat),
    .latchFlat(latchFlat), .wrapHit(wrapHit)
  );
endmodule

// File: rtl/splitCtrChecker.sv
module splitCtrChecker
  import split_ctr_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWr,
  input logic                    regRd,
  input logic [ADDR_W-1:0]       regAddr,
  input logic [BUS_W-1:0]        wrData,
  input logic [BUS_W-1:0]        rdData,
  input logic                    irqOut,
  input logic [PHYS_N*REG_W-1:0] liveFlat,
  input logic [PHYS_N*REG_W-1:0] latchFlat,
  input logic                    enableQ,
  input logic [LOG_N-1:0]        statusQ,
  input logic [LOG_N-1:0]        maskQ
);
  logic commitNow;
  logic statRead;
  assign commitNow = regWr && (regAddr == ADDR_W'(GLOB_ADDR)) && wrData[BUS_W-REG_W+EN_BIT];
  assign statRead  = regRd && (regAddr == ADDR_W'(STAT_ADDR));

  assert_commit_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> liveFlat == $past(latchFlat));

  assert_halt_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !commitNow) |=> $stable(liveFlat));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !statRead |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  assert_status_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    statRead |=> rdData[BUS_W-1 -: REG_W] == REG_W'($past(statusQ)));

  assert_mask_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);

  assert_low_half_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> rdData[BUS_W-REG_W-1:0] == '0);
endmodule

bind splitCtrBank splitCtrChecker uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .liveFlat(liveFlat),
  .latchFlat(latchFlat), .enableQ(enableQ), .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/tb_splitCtrBank.sv
module tb_splitCtrBank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [63:0] wrData = '0;
  logic [7:0]  events = '0;
  logic [63:0] rdData;
  logic        irqOut;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  splitCtrBank dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .events(events), .rdData(rdData), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [31:0] mLive [4];
  logic [31:0] mLatch [4];
  logic [31:0] mCtl [8];
  logic [31:0] mGlob = '0;
  logic [7:0]  mStat = '0;
  logic [7:0]  mMask = '0;
  logic [63:0] mRd = '0;
  logic        mIrq;
  assign mIrq = |(mStat & mMask);

  always @(posedge clk) begin
    logic [31:0] rv, wv;
    logic [15:0] hi, lo;
    logic [7:0]  wraps;
    bit          commit;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mLive[i] = '0; mLatch[i] = '0; end
      for (int i = 0; i < 8; i++) mCtl[i] = '0;
      mGlob = '0; mStat = '0; mMask = '0; mRd = '0;
    end else begin
      rv = '0;
      if (regAddr < 4)                        rv = mLive[regAddr[1:0]];
      else if (regAddr >= 8 && regAddr < 16)  rv = mCtl[regAddr[2:0]];
      else if (regAddr == 16)                 rv = mGlob;
      else if (regAddr == 17)                 rv = {24'd0, mStat};
      wv = wrData[63:32];
      commit = regWr && regAddr == 16 && wv[31];
      wraps = '0;
      for (int n = 0; n < 4; n++) begin
        if (commit) mLive[n] = mLatch[n];
        else if (mGlob[31]) begin
          if (mGlob[n]) begin
            hi = mLive[n][31:16]; lo = mLive[n][15:0];
            if (mCtl[n][0] && events[n]) begin
              if (hi == 16'hFFFF) wraps[n] = 1'b1;
              hi = hi + 16'd1;
            end
            if (mCtl[n+4][0] && events[n+4]) begin
              if (lo == 16'hFFFF) wraps[n+4] = 1'b1;
              lo = lo + 16'd1;
            end
            mLive[n] = {hi, lo};
          end else if (mCtl[n][0] && events[n]) begin
            if (mLive[n] == 32'hFFFF_FFFF) wraps[n] = 1'b1;
            mLive[n] = mLive[n] + 32'd1;
          end
        end
      end
      if (regRd && regAddr == 17) mStat = '0;
      mStat = mStat | wraps;
      if (regWr) begin
        if (regAddr < 4)                       mLatch[regAddr[1:0]] = wv;
        else if (regAddr >= 8 && regAddr < 16) mCtl[regAddr[2:0]] = wv;
        else if (regAddr == 16)                mGlob = wv;
        else if (regAddr == 17)                mMask = wv[7:0];
      end
      if (regRd) mRd = {rv, 32'd0};
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      if (rdData !== mRd || irqOut !== mIrq) begin
        miscompares++;
        $display("FAIL %s: rdData=%h irq=%0b expected rdData=%h irq=%0b",
                 curReq, rdData, irqOut, mRd, mIrq);
      end
    end
  end

  task automatic op(input bit w, input bit r, input logic [4:0] a,
                    input logic [31:0] v, input logic [7:0] ev);
    regWr = w; regRd = r; regAddr = a; wrData = {v, 32'hA5A5_5A5A}; events = ev;
    @(negedge clk); #1;
    regWr = 1'b0; regRd = 1'b0; events = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    op(1'b1, 1'b0, a, v, 8'h00);
  endtask

  task automatic expectRd(input logic [4:0] a, input logic [31:0] exp, input string req);
    op(1'b0, 1'b1, a, 32'h0, 8'h00);
    vectors++;
    if (rdData !== {exp, 32'd0}) begin
      miscompares++;
      $display("FAIL %s: addr %0d read %h expected %h", req, a, rdData, {exp, 32'd0});
    end
  endtask

  task automatic expectIrq(input logic exp, input string req);
    vectors++;
    if (irqOut !== exp) begin
      miscompares++;
      $display("FAIL %s: irqOut=%0b expected %0b", req, irqOut, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    curReq = "R1";
    expectIrq(1'b0, "R1");
    expectRd(5'd0, 32'h0, "R1");
    expectRd(5'd16, 32'h0, "R1");
    expectRd(5'd17, 32'h0, "R1");

    // R11: control register readback
    curReq = "R11";
    wr(5'd8, 32'h1); wr(5'd12, 32'h1); wr(5'd9, 32'h1); wr(5'd13, 32'h1);
    wr(5'd10, 32'h1); wr(5'd11, 32'h8000_0001);
    expectRd(5'd11, 32'h8000_0001, "R11");

    // R2: latch then commit
    curReq = "R2";
    wr(5'd0, 32'd100);
    expectRd(5'd0, 32'h0, "R2");
    wr(5'd16, 32'h8000_0000);
    expectRd(5'd0, 32'd100, "R2");
    expectRd(5'd16, 32'h8000_0000, "R11");

    // R4: 32-bit counting, event 4 ignored
    curReq = "R4";
    for (int i = 0; i < 7; i++) op(1'b0, 1'b0, 5'd0, 32'h0, 8'h11);
    expectRd(5'd0, 32'd107, "R4");

    // R6: stopped bank holds
    curReq = "R6";
    wr(5'd16, 32'h0);
    for (int i = 0; i < 5; i++) op(1'b0, 1'b0, 5'd0, 32'h0, 8'hFF);
    expectRd(5'd0, 32'd107, "R6");

    // R5 / R7: split counter 1, both halves roll over
    curReq = "R5";
    wr(5'd1, 32'hFFFE_FFFD);
    wr(5'd16, 32'h8000_0002);
    for (int i = 0; i < 3; i++) op(1'b0, 1'b0, 5'd0, 32'h0, 8'h22);
    expectRd(5'd1, 32'h0001_0000, "R5");

    // R9: mask enables interrupt
    curReq = "R9";
    wr(5'd17, 32'h22);
    expectIrq(1'b1, "R9");

    // R8: read returns and clears
    curReq = "R8";
    expectRd(5'd17, 32'h22, "R8");
    expectIrq(1'b0, "R8");
    expectRd(5'd17, 32'h0, "R8");

    // R3 + R8: reload while running, then read collides with roll-over
    curReq = "R3";
    wr(5'd2, 32'hFFFF_FFFF);
    wr(5'd16, 32'h8000_0002);
    expectRd(5'd2, 32'hFFFF_FFFF, "R3");
    curReq = "R8";
    op(1'b0, 1'b1, 5'd17, 32'h0, 8'h04);
    vectors++;
    if (rdData !== 64'd0) begin
      miscompares++;
      $display("FAIL R8: collision read %h expected %h", rdData, 64'd0);
    end
    expectRd(5'd17, 32'h04, "R8");
    expectRd(5'd2, 32'h0, "R7");

    // R3: reload beats increment in the same cycle
    curReq = "R3";
    op(1'b1, 1'b0, 5'd16, 32'h8000_0002, 8'h01);
    expectRd(5'd0, 32'd100, "R3");

    // R9 / R7: mask zero keeps irq low while a bit is pending
    curReq = "R9";
    wr(5'd17, 32'h0);
    wr(5'd3, 32'hFFFF_0000);
    wr(5'd16, 32'h8000_000A);
    op(1'b0, 1'b0, 5'd0, 32'h0, 8'h08);
    expectIrq(1'b0, "R9");
    expectRd(5'd17, 32'h08, "R7");

    // R10: unmapped address reads zero
    expectRd(5'd20, 32'h0, "R10");

    // Mixed traffic against the model
    curReq = "R4/R5/R7/R8";
    wr(5'd17, 32'hFF);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ev;
      ev = 8'(i * 37) ^ 8'(i >> 2);
      case (i % 23)
        0:  op(1'b1, 1'b0, 5'd16, 32'h8000_0000 | 32'(i % 16), ev);
        5:  op(1'b1, 1'b0, 5'(i % 4), 32'hFFFF_FFF0 + 32'(i % 13), ev);
        9:  op(1'b0, 1'b1, 5'd17, 32'h0, ev);
        13: op(1'b1, 1'b0, 5'(8 + (i % 8)), 32'(i % 3 != 0), ev);
        17: op(1'b0, 1'b1, 5'(i % 4), 32'h0, ev);
        default: op(1'b0, 1'b0, 5'd0, 32'h0, ev);
      endcase
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule